// File: doc/BRIEF.md
# Nested Interrupt Priority Resolver

This block watches a parameterised set of level-sensitive interrupt lines and decides which one the processor should take next. Each line has an 8-bit priority register. Only the upper PRIO_BITS bits exist, and a numerically smaller value is more urgent. A grouping setting splits the implemented bits into an upper preempt field and a lower subpriority field. The preempt field decides whether a request may interrupt the running handler. The subpriority field only orders requests that share a preempt field.

A global mask stops every request. A threshold register stops only the requests whose priority is equal to or less urgent than the threshold. Configuration uses a write strobe, an address and a data byte, and every register can be read back combinationally on `cfg_rdata`.

The resolver offers a take request that carries the IRQ index. It holds that request until the processor acknowledges it. Each acknowledged handler is pushed on a stack of active handlers, and an exit pulse pops the most recent one. The current execution level is the most urgent preempt field among the active handlers, or idle when no handler is active.

A two-state controller drives the offer. WATCH moves to OFFER when an eligible winner exists (transition *grant*). OFFER returns to WATCH when `take_ack` arrives (transition *accept*). While in OFFER the index is frozen.

Top module: `irq_prio_resolver`

## Requirements
- R1: After reset, all priority, grouping, global-mask and threshold registers read zero, `take_req` is low and `exec_idle` is high.
- R2: The register map is: addresses 0..NUM_IRQ-1 hold the priorities, NUM_IRQ holds grouping (bits 2:0), NUM_IRQ+1 holds the global mask (bit 0) and NUM_IRQ+2 holds the threshold. Priority and threshold keep only their top PRIO_BITS bits, and their lower bits read back zero.
- R3: Among eligible pending lines, the smallest priority value wins, and equal values go to the lower index.
- R4: Grouping value g gives the lowest min(g, PRIO_BITS-1) implemented bits to subpriority. Among requests with equal preempt fields, the smaller subpriority is taken first.
- R5: While a handler is active, a request is offered only if its preempt field is strictly smaller than the execution level. An equal preempt field with a better subpriority does not preempt.
- R6: While the global mask bit is 1, no request is offered.
- R7: A non-zero threshold blocks every request whose priority is greater than or equal to it. A zero threshold blocks nothing.
- R8: `take_req` stays high with a stable `take_idx` until `take_ack` arrives. The acknowledge clears that line's pending state, pushes the handler, and updates `exec_level` one cycle later.
- R9: `exit_req` pops the most recently pushed handler. A line still asserted after its handler exits becomes pending and is offered again.
- R10: `take_req` rises two clock edges after an eligible line is asserted while the core is idle.
- R11: `exec_level` shows the smallest preempt field (MSB-aligned, subpriority bits zero) among the active handlers. `exec_idle` is high when no handler is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_lines | input | NUM_IRQ | Level-sensitive interrupt requests |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Combinational read data at `cfg_addr` |
| take_req | output | 1 | Offer of an interrupt to the processor |
| take_idx | output | IDX_W | Index of the offered interrupt |
| take_ack | input | 1 | Processor accepts the offer |
| exit_req | input | 1 | Most recent handler has finished |
| exec_idle | output | 1 | No handler is active |
| exec_level | output | 8 | Current execution level, MSB-aligned preempt field |

## Verification
A line asserted while the core is idle becomes pending on the first edge, and `take_req` follows on the second edge. A request unblocked by an acknowledge, an exit or a configuration write is offered one edge after that event. An exiting handler whose line is still high needs two edges to be offered again. `exec_level` and `exec_idle` change on the same edge that accepts the acknowledge or the exit. Each bench task drives its stimulus just after a falling edge, counts exactly these rising edges, and samples at the next falling edge. Every "nothing is offered" case is held for several cycles before it is sampled.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
    typedef enum logic {
        ST_WATCH = 1'b0,
        ST_OFFER = 1'b1
    } resolver_state_e;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
    parameter int NUM_IRQ   = 8,
    parameter int PRIO_BITS = 3,
    parameter int ADDR_W    = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              we,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [7:0]                        wdata,
    output logic [7:0]                        rdata,
    output logic [NUM_IRQ-1:0][PRIO_BITS-1:0] prio_o,
    output logic [2:0]                        group_o,
    output logic                              gmask_o,
    output logic [PRIO_BITS-1:0]              thresh_o
);
    localparam logic [ADDR_W-1:0] ADDR_GRP = ADDR_W'(NUM_IRQ);
    localparam logic [ADDR_W-1:0] ADDR_GMK = ADDR_W'(NUM_IRQ + 1);
    localparam logic [ADDR_W-1:0] ADDR_THR = ADDR_W'(NUM_IRQ + 2);

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_prio
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                prio_o[i] <= '0;
            else if (we && addr == ADDR_W'(i))
                prio_o[i] <= wdata[7 -: PRIO_BITS];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            group_o  <= '0;
            gmask_o  <= 1'b0;
            thresh_o <= '0;
        end else if (we) begin
            if (addr == ADDR_GRP) group_o  <= wdata[2:0];
            if (addr == ADDR_GMK) gmask_o  <= wdata[0];
            if (addr == ADDR_THR) thresh_o <= wdata[7 -: PRIO_BITS];
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_IRQ; i++)
            if (addr == ADDR_W'(i)) rdata[7 -: PRIO_BITS] = prio_o[i];
        if (addr == ADDR_GRP) rdata[2:0] = group_o;
        if (addr == ADDR_GMK) rdata[0] = gmask_o;
        if (addr == ADDR_THR) rdata[7 -: PRIO_BITS] = thresh_o;
    end

    p_thresh_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_THR) |=> (thresh_o == $past(wdata[7 -: PRIO_BITS])));
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int NUM_IRQ   = 8,
    parameter int PRIO_BITS = 3,
    parameter int IDX_W     = 3
) (
    input  logic [NUM_IRQ-1:0]                pend,
    input  logic [NUM_IRQ-1:0][PRIO_BITS-1:0] prio,
    input  logic [PRIO_BITS-1:0]              thresh,
    output logic                              found,
    output logic [IDX_W-1:0]                  win_idx,
    output logic [PRIO_BITS-1:0]              win_prio
);
    always_comb begin
        found    = 1'b0;
        win_idx  = '0;
        win_prio = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (pend[i] && (thresh == '0 || prio[i] < thresh)) begin
                if (!found || prio[i] < win_prio) begin
                    found    = 1'b1;
                    win_idx  = IDX_W'(i);
                    win_prio = prio[i];
                end
            end
        end
    end
endmodule

// File: rtl/irq_active_stack.sv
module irq_active_stack #(
    parameter int NUM_IRQ   = 8,
    parameter int PRIO_BITS = 3,
    parameter int IDX_W     = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              push,
    input  logic [IDX_W-1:0]                  push_idx,
    input  logic                              pop_req,
    input  logic [NUM_IRQ-1:0][PRIO_BITS-1:0] prio,
    input  logic [PRIO_BITS-1:0]              pmask,
    output logic [NUM_IRQ-1:0]                act_o,
    output logic                              idle_o,
    output logic [PRIO_BITS-1:0]              level_o
);
    localparam int DW = $clog2(NUM_IRQ + 1);

    logic [NUM_IRQ-1:0][IDX_W-1:0] stk_q;
    logic [DW-1:0]                 depth_q;
    logic [DW-1:0]                 base;
    logic [IDX_W-1:0]              top_idx;
    logic                          do_pop;
    logic [NUM_IRQ-1:0]            act_n;

    assign do_pop = pop_req && (depth_q != '0);
    assign base   = depth_q - DW'(do_pop);

    always_comb begin
        top_idx = '0;
        for (int k = 0; k < NUM_IRQ; k++)
            if (DW'(k + 1) == depth_q) top_idx = stk_q[k];
    end

    always_comb begin
        act_n = act_o;
        if (do_pop) act_n[top_idx] = 1'b0;
        if (push)   act_n[push_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stk_q   <= '0;
            depth_q <= '0;
            act_o   <= '0;
        end else begin
            for (int k = 0; k < NUM_IRQ; k++)
                if (push && DW'(k) == base) stk_q[k] <= push_idx;
            depth_q <= base + DW'(push);
            act_o   <= act_n;
        end
    end

    always_comb begin
        idle_o  = 1'b1;
        level_o = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (act_o[i] && (idle_o || (prio[i] & pmask) < level_o)) begin
                idle_o  = 1'b0;
                level_o = prio[i] & pmask;
            end
        end
    end

    p_push_inactive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !act_o[push_idx]);
    p_depth_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        depth_q <= DW'(NUM_IRQ));
    p_depth_tracks_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(act_o) == int'(depth_q));
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
    import irq_prio_pkg::*;
#(
    parameter int NUM_IRQ   = 8,
    parameter int PRIO_BITS = 3,
    localparam int ADDR_W   = $clog2(NUM_IRQ + 3),
    localparam int IDX_W    = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_lines,
    input  logic               cfg_we,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [7:0]         cfg_wdata,
    output logic [7:0]         cfg_rdata,
    output logic               take_req,
    output logic [IDX_W-1:0]   take_idx,
    input  logic               take_ack,
    input  logic               exit_req,
    output logic               exec_idle,
    output logic [7:0]         exec_level
);
    logic [NUM_IRQ-1:0][PRIO_BITS-1:0] prio;
    logic [2:0]                        group;
    logic                              gmask;
    logic [PRIO_BITS-1:0]              thresh;
    logic [NUM_IRQ-1:0]                pend_q, act, clr;
    logic                              found, go, push;
    logic [IDX_W-1:0]                  win_idx, idx_q;
    logic [PRIO_BITS-1:0]              win_prio, level, pmask;
    int                                sub_eff;
    resolver_state_e                   state_q, state_n;

    irq_cfg_regs #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS), .ADDR_W(ADDR_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .rdata(cfg_rdata), .prio_o(prio), .group_o(group), .gmask_o(gmask),
        .thresh_o(thresh));

    irq_pick #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS), .IDX_W(IDX_W)) u_pick (
        .pend(pend_q), .prio(prio), .thresh(thresh), .found(found),
        .win_idx(win_idx), .win_prio(win_prio));

    irq_active_stack #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS), .IDX_W(IDX_W)) u_stack (
        .clk(clk), .rst_n(rst_n), .push(push), .push_idx(idx_q), .pop_req(exit_req),
        .prio(prio), .pmask(pmask), .act_o(act), .idle_o(exec_idle), .level_o(level));

    always_comb begin
        sub_eff = (int'(group) > PRIO_BITS - 1) ? PRIO_BITS - 1 : int'(group);
        pmask   = {PRIO_BITS{1'b1}} << sub_eff;
    end

    assign push = (state_q == ST_OFFER) && take_ack;
    assign go   = found && !gmask && (exec_idle || (win_prio & pmask) < level);

    always_comb begin
        clr = '0;
        if (push) clr[idx_q] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q | (irq_lines & ~act)) & ~clr;
    end

    // state register and offered index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WATCH;
            idx_q   <= '0;
        end else begin
            state_q <= state_n;
            if (state_q == ST_WATCH && go) idx_q <= win_idx;
        end
    end

    // next state and outputs
    always_comb begin
        state_n    = state_q;
        exec_level = '0;
        exec_level[7 -: PRIO_BITS] = level;
        take_req   = (state_q == ST_OFFER);
        take_idx   = idx_q;
        unique case (state_q)
            ST_WATCH: if (go)       state_n = ST_OFFER;
            ST_OFFER: if (take_ack) state_n = ST_WATCH;
        endcase
    end

    p_offer_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (take_req && !take_ack) |=> (take_req && $stable(take_idx)));
    p_gmask_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(take_req) |-> !$past(gmask));
    p_offer_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take_req |-> pend_q[take_idx]);
endmodule

// File: tb/test_irq_prio_resolver.sv
module test_irq_prio_resolver;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;
    localparam int P = 3;
    localparam int AW = $clog2(N + 3);
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_lines = '0;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [7:0]    cfg_wdata = '0;
    logic [7:0]    cfg_rdata;
    logic          take_req;
    logic [IW-1:0] take_idx;
    logic          take_ack = 1'b0;
    logic          exit_req = 1'b0;
    logic          exec_idle;
    logic [7:0]    exec_level;
    int            checks = 0;
    int            errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_prio_resolver #(.NUM_IRQ(N), .PRIO_BITS(P)) i_irq_prio_resolver (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .take_req(take_req), .take_idx(take_idx), .take_ack(take_ack),
        .exit_req(exit_req), .exec_idle(exec_idle), .exec_level(exec_level));

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h exp %0h", tag, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; irq_lines = '0; take_ack = 1'b0; exit_req = 1'b0; cfg_we = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = d;
        tick(1);
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input int a, input logic [7:0] exp);
        cfg_addr = AW'(a);
        #1;
        chk(tag, 32'(cfg_rdata), 32'(exp));
    endtask

    task automatic ack();
        take_ack = 1'b1; tick(1); take_ack = 1'b0;
    endtask

    task automatic leave();
        exit_req = 1'b1; tick(1); exit_req = 1'b0;
    endtask

    task automatic expect_take(input string tag, input int idx);
        chk(tag, 32'(take_req), 32'd1);
        chk(tag, 32'(take_idx), 32'(idx));
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 take_req", 32'(take_req), 32'd0);
        chk("R1 exec_idle", 32'(exec_idle), 32'd1);
        for (int a = 0; a < N + 3; a++) rd_chk("R1 reg", a, 8'h00);
    endtask

    task automatic t_readback();
        do_reset();
        wr(1, 8'hFF);
        rd_chk("R2 prio low bits", 1, 8'hE0);
        wr(N + 2, 8'h7F);
        rd_chk("R2 thresh low bits", N + 2, 8'h60);
        wr(N, 8'h02);
        rd_chk("R2 grouping", N, 8'h02);
    endtask

    task automatic t_winner();
        do_reset();
        wr(2, 8'h60); wr(5, 8'h20); wr(6, 8'h20);
        irq_lines = 8'b0110_0100;
        tick(1);
        chk("R10 not yet", 32'(take_req), 32'd0);
        tick(1);
        expect_take("R3 R10 winner", 5);
        ack();
        irq_lines = '0;
        chk("R8 level after ack", 32'(exec_level), 32'h20);
        chk("R11 busy", 32'(exec_idle), 32'd0);
        tick(3);
        chk("R5 equal preempt waits", 32'(take_req), 32'd0);
        leave();
        chk("R11 idle after exit", 32'(exec_idle), 32'd1);
        tick(1);
        expect_take("R3 next", 6);
        ack(); leave(); tick(1);
        expect_take("R3 last", 2);
        ack(); leave();
    endtask

    task automatic t_preempt();
        do_reset();
        wr(3, 8'h80); wr(4, 8'h20);
        irq_lines = 8'b0000_1000;
        tick(2);
        expect_take("R10 first", 3);
        ack();
        irq_lines = 8'b0001_0000;
        chk("R11 level 3", 32'(exec_level), 32'h80);
        tick(2);
        expect_take("R5 preempt", 4);
        ack();
        chk("R11 nested level", 32'(exec_level), 32'h20);
        leave();
        chk("R9 pop restores", 32'(exec_level), 32'h80);
        tick(1);
        chk("R9 rearm pending", 32'(take_req), 32'd0);
        tick(1);
        expect_take("R9 reoffer", 4);
        ack();
        irq_lines = '0;
        leave(); leave();
        chk("R9 idle", 32'(exec_idle), 32'd1);
        tick(3);
        chk("R9 no stray", 32'(take_req), 32'd0);
    endtask

    task automatic t_subprio();
        do_reset();
        wr(N, 8'h01); wr(N + 1, 8'h01);
        wr(1, 8'h60); wr(2, 8'h40);
        irq_lines = 8'b0000_0110;
        tick(4);
        chk("R6 masked", 32'(take_req), 32'd0);
        wr(N + 1, 8'h00);
        tick(1);
        expect_take("R4 subprio", 2);
        ack();
        irq_lines = '0;
        chk("R11 preempt only", 32'(exec_level), 32'h40);
        tick(3);
        chk("R5 sub no preempt", 32'(take_req), 32'd0);
        leave(); tick(1);
        expect_take("R4 second", 1);
        ack(); leave();
    endtask

    task automatic t_threshold();
        do_reset();
        wr(0, 8'h60); wr(7, 8'h40); wr(N + 2, 8'h60);
        irq_lines = 8'b0000_0001;
        tick(4);
        chk("R7 equal blocked", 32'(take_req), 32'd0);
        irq_lines = 8'b1000_0001;
        tick(2);
        expect_take("R7 urgent passes", 7);
        ack();
        irq_lines = 8'b0000_0001;
        leave();
        tick(2);
        chk("R7 still blocked", 32'(take_req), 32'd0);
        wr(N + 2, 8'h00);
        tick(1);
        expect_take("R7 zero disables", 0);
        ack(); irq_lines = '0; leave();
    endtask

    initial begin
        t_reset();
        t_readback();
        t_winner();
        t_preempt();
        t_subprio();
        t_threshold();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R8 watchdog got 0 exp 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule